// File: doc/BRIEF.md
# Sector-Read Floppy Controller Register Emulator

This block presents a byte-wide register window to a processor that behaves like a floppy disk controller. Behind it there is no drive, only block storage. The processor sets the track, side and physical sector, then writes a read command. The block turns that geometry into a linear 512-byte block address and asks a storage back end for that block. It collects the 512 returned bytes into a sector buffer and raises a completion flag, which stays set until the processor issues the next read.

The processor reads the buffer back one byte at a time through a data register whose pointer advances by itself. A swap control exchanges the two 256-byte halves of the buffer as the processor sees them, so that an odd 256-byte logical sector can be taken from the upper half. Step commands move a modelled head position, and a track-zero flag reports when that head is at track 0. The register window also shows the disk-present and write-protect inputs, and it drives an activity LED that can be off, on or blinking.

Top module: `fdc_sector_emu`

## Requirements
- R1: After reset, status 1 (offset 2) reads 0x01 when no disk is present, status 2 (offset 3) reads 0x00, the storage request is low and the LED output is low.
- R2: The control (offset 0, bits 2:0), track (offset 4), sector (offset 5) and side (offset 6, bit 0) registers read back what was last written to them. The command register (offset 1) reads back the last command that was accepted.
- R3: A write of 0x40 to offset 1 starts a read, provided the block is idle, a disk is present and the sector is between 1 and 10. The storage request is then high for exactly one cycle, starting the cycle after the write. The request address is the base address plus (track*2+side)*10 + sector-1.
- R4: Status 1 bit 7 (busy) is high from the accepted read until the back end reports done or error. Any command written while busy is ignored. This includes step commands.
- R5: While busy, every byte flagged valid by the back end is stored in order from buffer index 0. The data register (offset 7) returns the byte at a pointer that an accepted read resets to 0 and that each data read advances by one.
- R6: Control bit 0 (swap) inverts bit 8 of the buffer index seen through the data register.
- R7: When the back end reports done, status 2 bit 7 (read complete) is set. It stays set through any number of register reads and is cleared only by the next accepted read command.
- R8: When the back end reports an error, status 1 bit 4 (record not found) is set and busy clears.
- R9: A read command given with no disk present, or with sector 0 or a sector above 10, sets record-not-found and issues no storage request.
- R10: Command 0x18 moves the head one track inward, saturating at track 79. Command 0x10 moves it one track outward, saturating at 0. Status 1 bit 0 is high exactly when the head is at track 0.
- R11: Status 1 bit 6 shows the disk-present input and status 1 bit 5 shows the write-protect input.
- R12: Control bits 2:1 select the LED: 0 is off, 1 is on, 2 or 3 is blinking with a toggle every BLINK_HALF cycles.
- R13: Bytes flagged valid by the back end while idle do not change the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 3 | Register offset |
| cpuWe | input | 1 | Register write strobe |
| cpuRe | input | 1 | Register read strobe (advances the data pointer at offset 7) |
| cpuWdata | input | 8 | Write data |
| cpuRdata | output | 8 | Read data for the selected offset |
| diskPresent | input | 1 | A disk image is mounted |
| writeProtect | input | 1 | The mounted image is read-only |
| diskBase | input | ADDR_W | Block address of the image's first sector |
| stReq | output | 1 | One-cycle request to the storage back end |
| stAddr | output | ADDR_W | Requested 512-byte block address |
| stValid | input | 1 | Returned byte is valid |
| stData | input | 8 | Returned byte |
| stDone | input | 1 | Transfer finished successfully |
| stErr | input | 1 | Transfer failed |
| ledOut | output | 1 | Drive activity LED |

## Verification
The bench goes after the polling contracts first. A completion flag that cleared itself after a status read would leave a processor polling loop unable to see the result. A track-zero flag not tied to the head would hang a step-outward loop, and the bench checks it at both saturation ends. It checks that the swap remaps only bit 8 of the index, which catches a design that swapped nothing or scrambled the low bits. It sends stray bytes while idle, then reads index 0, to catch a fill path that is not gated by busy. It also confirms that a read refused for a missing disk or an out-of-range sector produces no request. A design that failed here would fetch an unrelated block.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_CMD    = 3'd1;
  localparam logic [2:0] OFS_STAT1  = 3'd2;
  localparam logic [2:0] OFS_STAT2  = 3'd3;
  localparam logic [2:0] OFS_TRACK  = 3'd4;
  localparam logic [2:0] OFS_SECTOR = 3'd5;
  localparam logic [2:0] OFS_SIDE   = 3'd6;
  localparam logic [2:0] OFS_DATA   = 3'd7;

  localparam logic [7:0] CMD_READ     = 8'h40;
  localparam logic [7:0] CMD_STEP_OUT = 8'h10;
  localparam logic [7:0] CMD_STEP_IN  = 8'h18;

  typedef struct packed {
    logic startRead;
    logic fillByte;
    logic stepIn;
    logic stepOut;
  } fdcStrobe_t;

  typedef enum logic { ST_IDLE, ST_FILL } fdcState_t;

endpackage

// File: rtl/fdc_ctrl.sv
module fdc_ctrl
  import fdc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic [7:0] cmdByte,
  input  logic       diskPresent,
  input  logic       sectorOk,
  input  logic       stValid,
  input  logic       stDone,
  input  logic       stErr,
  output fdcStrobe_t strobe,
  output logic       busy,
  output logic       rnf,
  output logic       rdreq
);

  fdcState_t state;
  logic      idleCmd;
  logic      isRead;
  logic      goRead;

  assign busy    = (state == ST_FILL);
  assign idleCmd = cmdWr && !busy;
  assign isRead  = idleCmd && (cmdByte == CMD_READ);
  assign goRead  = isRead && diskPresent && sectorOk;

  always_comb begin
    strobe           = '0;
    strobe.startRead = goRead;
    strobe.fillByte  = busy && stValid;
    strobe.stepIn    = idleCmd && (cmdByte == CMD_STEP_IN);
    strobe.stepOut   = idleCmd && (cmdByte == CMD_STEP_OUT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rnf   <= 1'b0;
      rdreq <= 1'b0;
    end else if (isRead) begin
      rdreq <= 1'b0;
      rnf   <= !goRead;
      state <= goRead ? ST_FILL : ST_IDLE;
    end else if (busy && stErr) begin
      rnf   <= 1'b1;
      state <= ST_IDLE;
    end else if (busy && stDone) begin
      rdreq <= 1'b1;
      state <= ST_IDLE;
    end
  end

endmodule

// File: rtl/fdc_data.sv
module fdc_data
  import fdc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUF_BYTES  = 512,
  parameter int MAX_TRACK  = 80,
  parameter int SECTORS    = 10,
  parameter int SIDES      = 2,
  parameter int BLINK_HALF = 250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cpuAddr,
  input  logic              cpuWe,
  input  logic              cpuRe,
  input  logic [7:0]        cpuWdata,
  output logic [7:0]        cpuRdata,
  input  fdcStrobe_t        strobe,
  input  logic              busy,
  input  logic              rnf,
  input  logic              rdreq,
  input  logic              diskPresent,
  input  logic              writeProtect,
  input  logic [ADDR_W-1:0] diskBase,
  input  logic [7:0]        stData,
  output logic              sectorOk,
  output logic              stReq,
  output logic [ADDR_W-1:0] stAddr,
  output logic              ledOut
);

  localparam int BUF_AW  = $clog2(BUF_BYTES);
  localparam int BLINK_W = $clog2(BLINK_HALF) + 1;

  logic [2:0]         ctrlReg;
  logic [7:0]         cmdReg;
  logic [7:0]         trackReg;
  logic [7:0]         sectorReg;
  logic               sideReg;
  logic [7:0]         headPos;
  logic [BUF_AW-1:0]  rdPtr;
  logic [BUF_AW-1:0]  fillIdx;
  logic [BUF_AW-1:0]  viewIdx;
  logic [7:0]         bufMem [BUF_BYTES];
  logic [ADDR_W-1:0]  lba;
  logic [BLINK_W-1:0] blinkCnt;
  logic               blinkPhase;
  logic               swapEn;
  logic [1:0]         ledMode;

  assign swapEn  = ctrlReg[0];
  assign ledMode = ctrlReg[2:1];

  assign sectorOk = (sectorReg != 8'd0) && (sectorReg <= 8'(SECTORS));

  always_comb begin
    lba = ADDR_W'(trackReg) * ADDR_W'(SIDES) + ADDR_W'(sideReg);
    lba = lba * ADDR_W'(SECTORS) + ADDR_W'(sectorReg) - ADDR_W'(1);
  end

  always_comb begin
    viewIdx             = rdPtr;
    viewIdx[BUF_AW-1]   = rdPtr[BUF_AW-1] ^ swapEn;
  end

  // register file and head model
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      cmdReg    <= '0;
      trackReg  <= '0;
      sectorReg <= '0;
      sideReg   <= 1'b0;
      headPos   <= '0;
    end else begin
      if (cpuWe) begin
        case (cpuAddr)
          OFS_CTRL:   ctrlReg   <= cpuWdata[2:0];
          OFS_CMD:    if (!busy) cmdReg <= cpuWdata;
          OFS_TRACK:  trackReg  <= cpuWdata;
          OFS_SECTOR: sectorReg <= cpuWdata;
          OFS_SIDE:   sideReg   <= cpuWdata[0];
          default: ;
        endcase
      end
      if (strobe.stepIn && headPos < 8'(MAX_TRACK - 1)) headPos <= headPos + 8'd1;
      if (strobe.stepOut && headPos != 8'd0)            headPos <= headPos - 8'd1;
    end
  end

  // request generation and buffer pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stReq   <= 1'b0;
      stAddr  <= '0;
      rdPtr   <= '0;
      fillIdx <= '0;
    end else begin
      stReq <= strobe.startRead;
      if (strobe.startRead) begin
        stAddr  <= diskBase + lba;
        rdPtr   <= '0;
        fillIdx <= '0;
      end else begin
        if (strobe.fillByte) fillIdx <= fillIdx + 1'b1;
        if (cpuRe && cpuAddr == OFS_DATA) rdPtr <= rdPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillByte) bufMem[fillIdx] <= stData;
  end

  // LED drive
  always_ff @(posedge clk) begin
    if (!rstN || !ledMode[1]) begin
      blinkCnt   <= '0;
      blinkPhase <= 1'b0;
    end else if (blinkCnt == BLINK_W'(BLINK_HALF - 1)) begin
      blinkCnt   <= '0;
      blinkPhase <= !blinkPhase;
    end else begin
      blinkCnt <= blinkCnt + 1'b1;
    end
  end

  assign ledOut = ledMode[1] ? blinkPhase : ledMode[0];

  always_comb begin
    case (cpuAddr)
      OFS_CTRL:   cpuRdata = {5'd0, ctrlReg};
      OFS_CMD:    cpuRdata = cmdReg;
      OFS_STAT1:  cpuRdata = {busy, diskPresent, writeProtect, rnf, 3'd0, headPos == 8'd0};
      OFS_STAT2:  cpuRdata = {rdreq, 7'd0};
      OFS_TRACK:  cpuRdata = trackReg;
      OFS_SECTOR: cpuRdata = sectorReg;
      OFS_SIDE:   cpuRdata = {7'd0, sideReg};
      default:    cpuRdata = bufMem[viewIdx];
    endcase
  end

endmodule

// File: rtl/fdc_sector_emu.sv
module fdc_sector_emu
  import fdc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUF_BYTES  = 512,
  parameter int MAX_TRACK  = 80,
  parameter int SECTORS    = 10,
  parameter int SIDES      = 2,
  parameter int BLINK_HALF = 250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cpuAddr,
  input  logic              cpuWe,
  input  logic              cpuRe,
  input  logic [7:0]        cpuWdata,
  output logic [7:0]        cpuRdata,
  input  logic              diskPresent,
  input  logic              writeProtect,
  input  logic [ADDR_W-1:0] diskBase,
  output logic              stReq,
  output logic [ADDR_W-1:0] stAddr,
  input  logic              stValid,
  input  logic [7:0]        stData,
  input  logic              stDone,
  input  logic              stErr,
  output logic              ledOut
);

  fdcStrobe_t strobe;
  logic       busy;
  logic       rnf;
  logic       rdreq;
  logic       sectorOk;
  logic       cmdWr;

  assign cmdWr = cpuWe && (cpuAddr == OFS_CMD);

  fdc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdByte(cpuWdata),
    .diskPresent(diskPresent), .sectorOk(sectorOk),
    .stValid(stValid), .stDone(stDone), .stErr(stErr),
    .strobe(strobe), .busy(busy), .rnf(rnf), .rdreq(rdreq)
  );

  fdc_data #(
    .ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES), .MAX_TRACK(MAX_TRACK),
    .SECTORS(SECTORS), .SIDES(SIDES), .BLINK_HALF(BLINK_HALF)
  ) uData (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuRe(cpuRe),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .strobe(strobe), .busy(busy),
    .rnf(rnf), .rdreq(rdreq), .diskPresent(diskPresent),
    .writeProtect(writeProtect), .diskBase(diskBase), .stData(stData),
    .sectorOk(sectorOk), .stReq(stReq), .stAddr(stAddr), .ledOut(ledOut)
  );

endmodule

// File: rtl/fdc_sector_emu_chk.sv
module fdc_sector_emu_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] cpuAddr,
  input logic       cpuWe,
  input logic [7:0] cpuWdata,
  input logic       diskPresent,
  input logic       stReq,
  input logic       stDone,
  input logic       stErr,
  input logic       busy,
  input logic       rdreq
);

  logic readCmdIdle;
  assign readCmdIdle = cpuWe && cpuAddr == 3'd1 && cpuWdata == 8'h40 && !busy;

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    stReq |=> !stReq); // R3

  AST_REQ_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> stReq); // R3

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stDone && !stErr) |=> busy); // R4

  AST_NO_REQ_UNPROMPTED: assert property (@(posedge clk) disable iff (!rstN)
    (!readCmdIdle) |=> !stReq); // R4

  AST_DONE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stDone && !stErr) |=> (!busy && rdreq)); // R7

  AST_RDREQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rdreq && !readCmdIdle) |=> rdreq); // R7

  AST_NODISK_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && cpuAddr == 3'd1 && !diskPresent) |=> !stReq); // R9

endmodule

bind fdc_sector_emu fdc_sector_emu_chk uChk (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
  .cpuWdata(cpuWdata), .diskPresent(diskPresent), .stReq(stReq),
  .stDone(stDone), .stErr(stErr), .busy(busy), .rdreq(rdreq)
);

// File: tb/fdc_sector_emu_test.sv
`timescale 1ns/1ps
module fdc_sector_emu_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cpuAddr = '0;
  logic        cpuWe = 1'b0;
  logic        cpuRe = 1'b0;
  logic [7:0]  cpuWdata = '0;
  logic [7:0]  cpuRdata;
  logic        diskPresent = 1'b0;
  logic        writeProtect = 1'b0;
  logic [31:0] diskBase = 32'h0000_1000;
  logic        stReq;
  logic [31:0] stAddr;
  logic        stValid = 1'b0;
  logic [7:0]  stData = '0;
  logic        stDone = 1'b0;
  logic        stErr = 1'b0;
  logic        ledOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural model state
  bit          reqArm = 0;
  logic [31:0] expAddr = '0;
  bit          mBusy = 0;
  int          mTrack = 0, mSector = 0, mSide = 0;

  always #2.5 clk = ~clk;

  fdc_sector_emu #(.BLINK_HALF(4)) uut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuRe(cpuRe),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .diskPresent(diskPresent),
    .writeProtect(writeProtect), .diskBase(diskBase), .stReq(stReq),
    .stAddr(stAddr), .stValid(stValid), .stData(stData), .stDone(stDone),
    .stErr(stErr), .ledOut(ledOut)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i % 256) * 3 + (i / 256) * 128 + 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of the request strobe against the model (R3, R9)
  always @(posedge clk) begin
    #1;
    if (rstN && !finished) begin
      check(stReq === reqArm, "R3 request strobe", stReq, reqArm);
      if (reqArm) check(stAddr === expAddr, "R3 request address", stAddr, expAddr);
      reqArm = 0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWdata = d; cpuWe = 1'b1;
    if (a == 3'd4) mTrack = d;
    if (a == 3'd5) mSector = d;
    if (a == 3'd6) mSide = d[0];
    if (a == 3'd1 && d == 8'h40 && !mBusy && diskPresent && mSector >= 1 && mSector <= 10) begin
      reqArm = 1;
      expAddr = diskBase + 32'((mTrack * 2 + mSide) * 10 + mSector - 1);
      mBusy = 1;
    end
    @(negedge clk);
    cpuWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    cpuAddr = a; cpuRe = 1'b1;
    #1 v = cpuRdata;
    @(negedge clk);
    cpuRe = 1'b0;
  endtask

  task automatic feedSector();
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      stValid = 1'b1; stData = pat(i);
    end
    @(negedge clk);
    stValid = 1'b0; stDone = 1'b1;
    @(negedge clk);
    stDone = 1'b0; mBusy = 0;
  endtask

  task automatic failSector();
    @(negedge clk);
    stErr = 1'b1;
    @(negedge clk);
    stErr = 1'b0; mBusy = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int highs, edges;
    logic prevLed;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd2, v); check(v == 8'h01, "R1 status1 after reset", v, 8'h01);
    rd(3'd3, v); check(v == 8'h00, "R1 status2 after reset", v, 8'h00);
    check(ledOut == 1'b0, "R1 led after reset", ledOut, 0);
    check(stReq == 1'b0, "R1 request after reset", stReq, 0);

    // R2 register readback
    wr(3'd4, 8'd5); rd(3'd4, v); check(v == 8'd5, "R2 track readback", v, 5);
    wr(3'd5, 8'd3); rd(3'd5, v); check(v == 8'd3, "R2 sector readback", v, 3);
    wr(3'd6, 8'hFF); rd(3'd6, v); check(v == 8'h01, "R2 side readback", v, 1);
    wr(3'd0, 8'h07); rd(3'd0, v); check(v == 8'h07, "R2 control readback", v, 7);
    wr(3'd0, 8'h00);

    // R11 flag mirroring
    diskPresent = 1'b1; writeProtect = 1'b1;
    rd(3'd2, v); check(v == 8'h61, "R11 disk and protect flags", v, 8'h61);

    // R9 no disk: record not found, no request
    diskPresent = 1'b0;
    wr(3'd1, 8'h40);
    rd(3'd2, v); check(v == 8'h31, "R9 no disk sets record-not-found", v, 8'h31);

    // R9 sector 0 with disk present
    diskPresent = 1'b1; writeProtect = 1'b0;
    wr(3'd5, 8'd0); wr(3'd1, 8'h40);
    rd(3'd2, v); check(v == 8'h51, "R9 sector zero refused", v, 8'h51);
    wr(3'd5, 8'd11); wr(3'd1, 8'h40);
    rd(3'd2, v); check(v == 8'h51, "R9 sector eleven refused", v, 8'h51);

    // R3/R4 valid read: track 2 side 1 sector 3 -> base + 52
    wr(3'd4, 8'd2); wr(3'd6, 8'd1); wr(3'd5, 8'd3);
    wr(3'd1, 8'h40);
    rd(3'd2, v); check(v == 8'hC1, "R4 busy during transfer", v, 8'hC1);
    wr(3'd1, 8'h18);   // step while busy: ignored (R4)
    wr(3'd1, 8'h40);   // read while busy: no request (R4)
    rd(3'd1, v); check(v == 8'h40, "R4 command held while busy", v, 8'h40);
    feedSector();
    rd(3'd2, v); check(v == 8'h41, "R4 busy cleared, head still at 0", v, 8'h41);
    for (int k = 0; k < 3; k++) begin
      rd(3'd3, v); check(v == 8'h80, "R7 read complete stays set", v, 8'h80);
    end

    // R5 buffer readout, R6 swap
    for (int k = 0; k < 4; k++) begin
      rd(3'd7, v); check(v == pat(k), "R5 buffer byte", v, pat(k));
    end
    wr(3'd0, 8'h01);
    rd(3'd7, v); check(v == pat(260), "R6 swapped half", v, pat(260));
    rd(3'd7, v); check(v == pat(261), "R6 swapped half next", v, pat(261));

    // R13 stray bytes while idle
    @(negedge clk); stValid = 1'b1; stData = 8'hEE;
    @(negedge clk); stValid = 1'b0;

    // R8 error path (also clears read complete, R7)
    wr(3'd1, 8'h40);
    failSector();
    rd(3'd2, v); check(v == 8'h51, "R8 error sets record-not-found", v, 8'h51);
    rd(3'd3, v); check(v == 8'h00, "R7 cleared by next read", v, 8'h00);
    wr(3'd0, 8'h00);
    rd(3'd7, v); check(v == pat(0), "R13 idle bytes ignored", v, pat(0));

    // R10 stepping
    wr(3'd1, 8'h18); wr(3'd1, 8'h18); wr(3'd1, 8'h18);
    rd(3'd2, v); check(v[0] == 1'b0, "R10 off track zero after steps in", v[0], 0);
    wr(3'd1, 8'h10); wr(3'd1, 8'h10);
    rd(3'd2, v); check(v[0] == 1'b0, "R10 still off track zero", v[0], 0);
    wr(3'd1, 8'h10);
    rd(3'd2, v); check(v[0] == 1'b1, "R10 back at track zero", v[0], 1);
    wr(3'd1, 8'h10);
    rd(3'd2, v); check(v[0] == 1'b1, "R10 saturates at zero", v[0], 1);
    for (int k = 0; k < 85; k++) wr(3'd1, 8'h18);
    for (int k = 0; k < 79; k++) wr(3'd1, 8'h10);
    rd(3'd2, v); check(v[0] == 1'b1, "R10 saturates at track 79", v[0], 1);

    // R12 LED
    wr(3'd0, 8'h02); check(ledOut == 1'b1, "R12 led on", ledOut, 1);
    wr(3'd0, 8'h00); check(ledOut == 1'b0, "R12 led off", ledOut, 0);
    wr(3'd0, 8'h04);
    highs = 0; edges = 0; prevLed = ledOut;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (ledOut) highs++;
      if (ledOut != prevLed) edges++;
      prevLed = ledOut;
    end
    check(highs >= 6 && highs <= 10, "R12 blink duty", highs, 8);
    check(edges >= 3, "R12 blink toggles", edges, 4);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule